// File: doc/BRIEF.md
# MMC Bus-Mode Upgrade Sequencer

This block takes an MMC card that has already been identified and addressed and moves it to a wider data bus and high-speed timing. On a start pulse it looks at the specification-version field that was earlier read from the card's CSD. Cards older than version 4 are left alone, and the block reports completion without issuing anything. Newer cards are selected with command 7. The block then writes two bytes of the card's extended register with command 6: first the bus-width byte, then the high-speed byte.

Each command goes out on a plain issue interface: command index, response-type code, index-check and CRC-check enables, a 32-bit argument and a one-cycle issue strobe. A command engine behind that interface reports completion, completion-with-error, response timeout or CRC error, and it shows the card's busy line. The host-side bus-width and high-speed outputs change only after the matching switch command has completed cleanly and the card has released busy. Any failure, including a busy phase that runs too long, ends in a sticky error. When that happens the host configuration stays at its last good value.

Top module: `mmc_mode_upgrade_seq`

## Requirements
- R1: After reset host_width is 2'b00 (1-bit), host_hs is 0, and seq_done, seq_err and cmd_issue are 0.
- R2: When start is accepted and spec_vers is below SPEC_MIN (default 4), no command is issued, seq_done pulses on the next cycle, and the host configuration is unchanged.
- R3: The first command has index 7, response type 2'b10 and both check enables set, with the RCA parameter (default 1) in arg[31:16] and zeros in arg[15:0].
- R4: The second command has index 6, response type 2'b11 and both check enables set. Its argument is 0x03B7_xx00, where xx is 0, 1 or 2 for a TARGET_WIDTH of 1, 4 or 8.
- R5: host_width takes the target code (2'b00 = 1 bit, 2'b01 = 4 bits, 2'b10 = 8 bits) only after the width command has completed without error and card_busy is low. It never changes while the card is busy.
- R6: The third command has index 6, response type 2'b11 and argument 0x03B90100. host_hs rises once that command completes and card_busy is low.
- R7: cmd_err, cmd_tmo or cmd_crc_err seen while a response is awaited sets a sticky seq_err. No further command is issued, seq_done stays low, and host_width and host_hs keep their values. An error has priority over a completion in the same cycle.
- R8: If card_busy stays high for BUSY_LIMIT cycles after a switch command completes, the sequence aborts as in R7. A busy phase of BUSY_LIMIT-1 cycles is accepted.
- R9: A successful run, or a skipped one, raises seq_done for exactly one cycle.
- R10: start is ignored while a sequence is running. An accepted start clears seq_err.
- R11: cmd_issue is a one-cycle strobe. Commands go out in the order 7, 6 (width), 6 (high speed), and each is issued only after the previous one has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request pulse |
| spec_vers | input | SPEC_W | Spec-version field from the CSD |
| cmd_idx | output | 6 | Command index |
| cmd_rsp_type | output | 2 | Response-type code |
| cmd_idx_chk | output | 1 | Response index-check enable |
| cmd_crc_chk | output | 1 | Response CRC-check enable |
| cmd_arg | output | 32 | Command argument |
| cmd_issue | output | 1 | One-cycle issue strobe |
| cmd_done | input | 1 | Command completed |
| cmd_err | input | 1 | Command completed with error |
| cmd_tmo | input | 1 | Response timeout |
| cmd_crc_err | input | 1 | Response CRC error |
| card_busy | input | 1 | Card busy indication |
| host_width | output | 2 | Host bus-width code |
| host_hs | output | 1 | Host high-speed enable |
| seq_done | output | 1 | Success pulse |
| seq_err | output | 1 | Sticky error flag |

## Verification
The bench builds the block with RCA = 0x2A5C, TARGET_WIDTH = 8 and BUSY_LIMIT = 16. The non-default address shows that the whole 16-bit field lands in the upper half of the select argument. The 8-bit target puts byte value 2 into the width argument and code 2'b10 onto host_width. The small busy limit puts both sides of the timeout boundary (15 and 16 busy cycles) within a short run, and a model of the command engine injects each kind of fault at each step.

// File: rtl/mmc_upg_pkg.sv
package mmc_upg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SEL_ISS,
      ST_SEL_WAIT,
      ST_WID_ISS,
      ST_WID_WAIT,
      ST_WID_BUSY,
      ST_HS_ISS,
      ST_HS_WAIT,
      ST_HS_BUSY,
      ST_FIN,
      ST_ERR
   } upg_state_t;

   typedef enum logic [1:0] {
      K_SELECT = 2'd0,
      K_WIDTH  = 2'd1,
      K_SPEED  = 2'd2
   } cmd_kind_t;

   localparam logic [5:0] IDX_SELECT = 6'd7;
   localparam logic [5:0] IDX_SWITCH = 6'd6;
   localparam logic [1:0] RSP_R48    = 2'b10;
   localparam logic [1:0] RSP_R48B   = 2'b11;
   localparam logic [7:0] ACC_WRBYTE = 8'h03;
   localparam logic [7:0] XB_WIDTH   = 8'd183;
   localparam logic [7:0] XB_SPEED   = 8'd185;

   function automatic logic [1:0] width_code(input int bits);
      case (bits)
         8:       return 2'b10;
         4:       return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/mmc_upg_argfmt.sv
module mmc_upg_argfmt
   import mmc_upg_pkg::*;
#(
   parameter logic [15:0] RCA       = 16'h0001,
   parameter logic [1:0]  WCODE     = 2'b01
) (
   input  cmd_kind_t   kind,
   output logic [5:0]  idx,
   output logic [1:0]  rsp,
   output logic        idx_chk,
   output logic        crc_chk,
   output logic [31:0] arg
);
   localparam logic [7:0] WIDTH_VAL = {6'b0, WCODE};

   always_comb begin
      idx_chk = 1'b1;
      crc_chk = 1'b1;
      case (kind)
         K_SELECT: begin
            idx = IDX_SELECT;
            rsp = RSP_R48;
            arg = {RCA, 16'h0000};
         end
         K_WIDTH: begin
            idx = IDX_SWITCH;
            rsp = RSP_R48B;
            arg = {ACC_WRBYTE, XB_WIDTH, WIDTH_VAL, 8'h00};
         end
         default: begin
            idx = IDX_SWITCH;
            rsp = RSP_R48B;
            arg = {ACC_WRBYTE, XB_SPEED, 8'h01, 8'h00};
         end
      endcase
   end
endmodule

// File: rtl/mmc_upg_busytmr.sv
module mmc_upg_busytmr #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic busy,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("BUSY_LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run)       cnt_q <= '0;
      else if (busy)       cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && busy && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/mmc_mode_upgrade_seq.sv
module mmc_mode_upgrade_seq
   import mmc_upg_pkg::*;
#(
   parameter int          SPEC_W       = 4,
   parameter int          SPEC_MIN     = 4,
   parameter logic [15:0] RCA          = 16'h0001,
   parameter int          TARGET_WIDTH = 4,
   parameter int          BUSY_LIMIT   = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SPEC_W-1:0] spec_vers,
   output logic [5:0]        cmd_idx,
   output logic [1:0]        cmd_rsp_type,
   output logic              cmd_idx_chk,
   output logic              cmd_crc_chk,
   output logic [31:0]       cmd_arg,
   output logic              cmd_issue,
   input  logic              cmd_done,
   input  logic              cmd_err,
   input  logic              cmd_tmo,
   input  logic              cmd_crc_err,
   input  logic              card_busy,
   output logic [1:0]        host_width,
   output logic              host_hs,
   output logic              seq_done,
   output logic              seq_err
);
   localparam logic [1:0] WCODE = width_code(TARGET_WIDTH);

   generate
      if (!(TARGET_WIDTH == 1 || TARGET_WIDTH == 4 || TARGET_WIDTH == 8)) begin : g_bad_width
         $error("TARGET_WIDTH must be 1, 4 or 8");
      end
      if (SPEC_MIN >= (1 << SPEC_W)) begin : g_bad_spec
         $error("SPEC_MIN does not fit in SPEC_W bits");
      end
   endgenerate

   upg_state_t state_q, state_d;
   cmd_kind_t  kind;
   logic       fail, tmo_hit, in_busy;

   assign fail    = cmd_err | cmd_tmo | cmd_crc_err;
   assign in_busy = (state_q == ST_WID_BUSY) || (state_q == ST_HS_BUSY);

   mmc_upg_busytmr #(.LIMIT(BUSY_LIMIT)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (in_busy),
      .busy    (card_busy),
      .expired (tmo_hit)
   );

   always_comb begin
      case (state_q)
         ST_SEL_ISS, ST_SEL_WAIT: kind = K_SELECT;
         ST_WID_ISS, ST_WID_WAIT: kind = K_WIDTH;
         default:                 kind = K_SPEED;
      endcase
   end

   mmc_upg_argfmt #(.RCA(RCA), .WCODE(WCODE)) u_fmt (
      .kind    (kind),
      .idx     (cmd_idx),
      .rsp     (cmd_rsp_type),
      .idx_chk (cmd_idx_chk),
      .crc_chk (cmd_crc_chk),
      .arg     (cmd_arg)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:
            if (start)
               state_d = (spec_vers >= SPEC_W'(SPEC_MIN)) ? ST_SEL_ISS : ST_FIN;
         ST_SEL_ISS:  state_d = ST_SEL_WAIT;
         ST_SEL_WAIT:
            if (fail)          state_d = ST_ERR;
            else if (cmd_done) state_d = ST_WID_ISS;
         ST_WID_ISS:  state_d = ST_WID_WAIT;
         ST_WID_WAIT:
            if (fail)          state_d = ST_ERR;
            else if (cmd_done) state_d = ST_WID_BUSY;
         ST_WID_BUSY:
            if (!card_busy)    state_d = ST_HS_ISS;
            else if (tmo_hit)  state_d = ST_ERR;
         ST_HS_ISS:   state_d = ST_HS_WAIT;
         ST_HS_WAIT:
            if (fail)          state_d = ST_ERR;
            else if (cmd_done) state_d = ST_HS_BUSY;
         ST_HS_BUSY:
            if (!card_busy)    state_d = ST_FIN;
            else if (tmo_hit)  state_d = ST_ERR;
         ST_FIN:      state_d = ST_IDLE;
         ST_ERR:      state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         host_width <= 2'b00;
         host_hs    <= 1'b0;
         seq_err    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_WID_BUSY && !card_busy)
            host_width <= WCODE;
         if (state_q == ST_HS_BUSY && !card_busy)
            host_hs <= 1'b1;
         if (state_d == ST_ERR)
            seq_err <= 1'b1;
         else if (state_q == ST_IDLE && start)
            seq_err <= 1'b0;
      end
   end

   assign cmd_issue = (state_q == ST_SEL_ISS) || (state_q == ST_WID_ISS) ||
                      (state_q == ST_HS_ISS);
   assign seq_done  = (state_q == ST_FIN);

endmodule

// File: rtl/mmc_upg_checker.sv
module mmc_upg_checker #(
   parameter int TGT_WIDTH = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic [5:0]  cmd_idx,
   input logic [1:0]  cmd_rsp_type,
   input logic        cmd_idx_chk,
   input logic        cmd_crc_chk,
   input logic [31:0] cmd_arg,
   input logic        cmd_issue,
   input logic        card_busy,
   input logic [1:0]  host_width,
   input logic        host_hs,
   input logic        seq_done,
   input logic        seq_err
);
   localparam logic [1:0] WC = (TGT_WIDTH == 8) ? 2'b10 :
                               (TGT_WIDTH == 4) ? 2'b01 : 2'b00;

   p_issue_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_issue |=> !cmd_issue);

   p_sel_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_issue && cmd_idx == 6'd7) |->
         (cmd_rsp_type == 2'b10 && cmd_idx_chk && cmd_crc_chk && cmd_arg[15:0] == 16'h0));

   p_switch_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_issue && cmd_idx == 6'd6) |->
         (cmd_rsp_type == 2'b11 && cmd_idx_chk && cmd_crc_chk &&
          cmd_arg[31:24] == 8'h03 && cmd_arg[7:0] == 8'h00 &&
          (cmd_arg[23:16] == 8'hB7 || cmd_arg[23:16] == 8'hB9)));

   p_width_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(host_width) |-> (!$past(card_busy) && host_width == WC));

   p_hs_after_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_hs |-> host_width == WC);

   p_cfg_hold_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_err) |-> ($stable(host_width) && $stable(host_hs)));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

endmodule

bind mmc_mode_upgrade_seq mmc_upg_checker #(.TGT_WIDTH(TARGET_WIDTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_idx      (cmd_idx),
   .cmd_rsp_type (cmd_rsp_type),
   .cmd_idx_chk  (cmd_idx_chk),
   .cmd_crc_chk  (cmd_crc_chk),
   .cmd_arg      (cmd_arg),
   .cmd_issue    (cmd_issue),
   .card_busy    (card_busy),
   .host_width   (host_width),
   .host_hs      (host_hs),
   .seq_done     (seq_done),
   .seq_err      (seq_err)
);

// File: tb/tb_mmc_mode_upgrade_seq.sv
module tb_mmc_mode_upgrade_seq;

   localparam logic [15:0] T_RCA   = 16'h2A5C;
   localparam int          T_WIDTH = 8;
   localparam int          T_LIMIT = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  spec_vers = 4'd0;
   logic [5:0]  cmd_idx;
   logic [1:0]  cmd_rsp_type;
   logic        cmd_idx_chk, cmd_crc_chk, cmd_issue;
   logic [31:0] cmd_arg;
   logic        cmd_done = 1'b0, cmd_err = 1'b0, cmd_tmo = 1'b0, cmd_crc_err = 1'b0;
   logic        card_busy = 1'b0;
   logic [1:0]  host_width;
   logic        host_hs, seq_done, seq_err;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   mmc_mode_upgrade_seq #(
      .SPEC_W(4), .SPEC_MIN(4), .RCA(T_RCA),
      .TARGET_WIDTH(T_WIDTH), .BUSY_LIMIT(T_LIMIT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .spec_vers(spec_vers),
      .cmd_idx(cmd_idx), .cmd_rsp_type(cmd_rsp_type), .cmd_idx_chk(cmd_idx_chk),
      .cmd_crc_chk(cmd_crc_chk), .cmd_arg(cmd_arg), .cmd_issue(cmd_issue),
      .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_tmo(cmd_tmo),
      .cmd_crc_err(cmd_crc_err), .card_busy(card_busy),
      .host_width(host_width), .host_hs(host_hs),
      .seq_done(seq_done), .seq_err(seq_err)
   );

   // fstep: command (1..3) whose response faults, 0 = none
   // fkind: 1 = completion with error, 2 = timeout, 3 = CRC error
   typedef struct packed {
      logic [3:0] spec;
      logic [1:0] fstep;
      logic [1:0] fkind;
      logic [7:0] wbusy;
      logic [7:0] hbusy;
      logic       restart;
      logic [1:0] ecmds;
      logic [1:0] ewidth;
      logic       ehs;
      logic       eerr;
      logic       edone;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{4'd3, 2'd0, 2'd0, 8'd0,  8'd0,  1'b0, 2'd0, 2'b00, 1'b0, 1'b0, 1'b1}, // R2 skip
      '{4'd4, 2'd0, 2'd0, 8'd3,  8'd2,  1'b0, 2'd3, 2'b10, 1'b1, 1'b0, 1'b1}, // R5 R6 boundary spec
      '{4'd9, 2'd0, 2'd0, 8'd0,  8'd0,  1'b0, 2'd3, 2'b10, 1'b1, 1'b0, 1'b1}, // no busy at all
      '{4'd5, 2'd1, 2'd1, 8'd0,  8'd0,  1'b0, 2'd1, 2'b00, 1'b0, 1'b1, 1'b0}, // R7 select error
      '{4'd5, 2'd2, 2'd2, 8'd0,  8'd0,  1'b0, 2'd2, 2'b00, 1'b0, 1'b1, 1'b0}, // R7 width timeout
      '{4'd5, 2'd3, 2'd3, 8'd2,  8'd0,  1'b0, 2'd3, 2'b10, 1'b0, 1'b1, 1'b0}, // R7 speed CRC
      '{4'd6, 2'd0, 2'd0, 8'd17, 8'd0,  1'b0, 2'd2, 2'b00, 1'b0, 1'b1, 1'b0}, // R8 width busy over
      '{4'd6, 2'd0, 2'd0, 8'd16, 8'd0,  1'b0, 2'd3, 2'b10, 1'b1, 1'b0, 1'b1}, // R8 width busy at edge
      '{4'd6, 2'd0, 2'd0, 8'd1,  8'd17, 1'b0, 2'd3, 2'b10, 1'b0, 1'b1, 1'b0}, // R8 speed busy over
      '{4'd4, 2'd0, 2'd0, 8'd4,  8'd4,  1'b1, 2'd3, 2'b10, 1'b1, 1'b0, 1'b1}, // R10 restart ignored
      '{4'd15,2'd2, 2'd1, 8'd0,  8'd0,  1'b0, 2'd2, 2'b00, 1'b0, 1'b1, 1'b0}  // R7 width error
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start = 1'b0;
      {cmd_done, cmd_err, cmd_tmo, cmd_crc_err, card_busy} = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_vec(input vec_t v, input bit with_reset, input int id);
      int  step = 0;
      int  wait_ctr = -1;
      int  busy_ctr = 0;
      int  dones = 0;
      bit  early = 1'b0;
      bit  fld_ok = 1'b1;
      logic [31:0] exp_arg;
      if (with_reset) do_reset();
      @(negedge clk);
      spec_vers = v.spec;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
      for (int cyc = 0; cyc < 120; cyc++) begin
         start = (v.restart && cyc == 6);
         {cmd_done, cmd_err, cmd_tmo, cmd_crc_err} = '0;
         if (busy_ctr > 0) busy_ctr--;
         if (wait_ctr == 0) begin
            if (v.fstep == step && v.fkind != 0) begin
               // error and completion together: error must win (R7)
               cmd_done = 1'b1;
               case (v.fkind)
                  2'd1:    cmd_err     = 1'b1;
                  2'd2:    cmd_tmo     = 1'b1;
                  default: cmd_crc_err = 1'b1;
               endcase
            end else begin
               cmd_done = 1'b1;
               if (step == 2) busy_ctr = v.wbusy;
               if (step == 3) busy_ctr = v.hbusy;
            end
            wait_ctr = -1;
         end else if (wait_ctr > 0) begin
            wait_ctr--;
         end
         card_busy = (busy_ctr > 0);
         if (card_busy && step == 2 && host_width != 2'b00) early = 1'b1;
         if (seq_done) dones++;
         if (cmd_issue) begin
            step++;
            case (step)
               1:       exp_arg = {T_RCA, 16'h0};
               2:       exp_arg = 32'h03B7_0200;
               default: exp_arg = 32'h03B9_0100;
            endcase
            if (cmd_idx != ((step == 1) ? 6'd7 : 6'd6) ||
                cmd_rsp_type != ((step == 1) ? 2'b10 : 2'b11) ||
                !cmd_idx_chk || !cmd_crc_chk || cmd_arg != exp_arg)
               fld_ok = 1'b0;
            if (!fld_ok)
               check(1'b0, $sformatf("R3 R4 R6 vec%0d cmd%0d fields", id, step),
                     cmd_arg, exp_arg);
            wait_ctr = 1;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check(fld_ok, $sformatf("R3 R4 R6 vec%0d command fields", id), 32'(fld_ok), 32'd1);
      check(step == v.ecmds, $sformatf("R11 vec%0d command count", id), step, v.ecmds);
      check(host_width == v.ewidth, $sformatf("R5 vec%0d host_width", id), host_width, v.ewidth);
      check(host_hs == v.ehs, $sformatf("R6 vec%0d host_hs", id), host_hs, v.ehs);
      check(seq_err == v.eerr, $sformatf("R7 R8 vec%0d seq_err", id), seq_err, v.eerr);
      check(dones == int'(v.edone), $sformatf("R9 vec%0d done pulses", id), dones, v.edone);
      check(!early, $sformatf("R5 vec%0d width changed while busy", id), early, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset();
      check(host_width == 2'b00, "R1 host_width", host_width, 0);
      check(!host_hs, "R1 host_hs", host_hs, 0);
      check(!seq_done && !seq_err, "R1 done/err", {seq_done, seq_err}, 0);
      check(!cmd_issue, "R1 cmd_issue", cmd_issue, 0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b1, i);

      // R10: error run, then a clean run without reset clears seq_err
      run_vec(VECS[3], 1'b1, 100);
      run_vec(VECS[1], 1'b0, 101);

      // R2: after an upgrade, a low-spec start keeps the configuration
      run_vec('{4'd2, 2'd0, 2'd0, 8'd0, 8'd0, 1'b0, 2'd0, 2'b10, 1'b1, 1'b0, 1'b1},
              1'b0, 102);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule